// File: doc/BRIEF.md
# Four-Lane Word Serializer with Forwarded Frame Clock

This block turns a 28-bit parallel word into five serial bit streams. Four lanes carry the data, seven bits each per word period. The fifth lane carries a forwarded clock whose seven-slot shape marks where each frame begins. The whole design runs on a fast bit clock at seven times the word rate. The slower word clock comes in as an ordinary input and is sampled in the bit-clock domain. A rising edge seen on it marks a frame boundary.

Each detected word-clock rise does two things at the same bit-clock edge. It captures the word on the parallel input into a hold register. It also moves the word held from the previous rise into the lane shift registers. A word therefore leaves the block one word period after it was captured. When word periods are exactly seven bit clocks, frames follow each other with no idle slot. The supported word-rate range is 20 to 85 MHz, which is 595 Mbit/s per lane at the top rate. A separate PLL is expected to supply the seven-times bit clock.

An active-low power-down input empties the shift registers and drops the lane output enable. The enable is the register-level stand-in for tri-stated line drivers. When power-down is released, the lanes stay quiet until the next word boundary, and then send a complete frame.

Top module: `ser7_lane_tx`

## Requirements
- R1: A word-clock rise counts only when the bit clock samples the word clock low and then high, with reset inactive. Releasing reset while the word clock is already high starts no frame.
- R2: Data lane k carries word bits 7k+6 down to 7k, in that order. Slot 0 is bit 7k+6, the highest-numbered bit of its group. Slot 0 appears on the bit-clock edge that detects the word-clock rise after the one that captured the word.
- R3: The frame-clock lane sends 1,1,0,0,0,1,1 in slots 0 to 6 of every frame, in step with slot 0 of the data lanes.
- R4: With word periods of exactly seven bit clocks, consecutive frames follow each other with no idle slot, and the output enable stays high.
- R5: Power-down low, as sampled at a bit-clock edge, clears the output enable and drives all five lanes to 0 at that edge.
- R6: After power-down is released, the output enable and all lanes stay low until the next word-clock rise. At that edge a full frame starts at slot 0, carrying the word captured at the previous rise.
- R7: Synchronous active-high reset clears the output enable, all lanes and the hold register. The first frame after reset therefore carries all-zero data, together with the normal frame-clock pattern.
- R8: If no word-clock rise arrives by the end of slot 6, all five lanes drive 0 with the output enable still high, until the next rise starts a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock, seven times the word rate |
| rst | input | 1 | Synchronous reset, active high |
| word_clk | input | 1 | Parallel word clock, sampled by bit_clk |
| pdown_n | input | 1 | Power-down, active low |
| tx_word | input | 28 | Parallel word, captured at a word-clock rise |
| lane_dat | output | 4 | Serial data lanes, bit k is lane k |
| lane_fclk | output | 1 | Forwarded frame-clock lane |
| lane_oe | output | 1 | Lane output enable (low means high impedance) |

## Verification
All five lane outputs and the enable are registers. Each therefore reflects the inputs sampled one bit-clock edge earlier. Slot 0 of a frame appears on the edge that detects a word-clock rise, and a power-down or reset takes effect on the very next edge. A captured word shows up exactly seven bit clocks after the edge that captured it. The bench drives every input on a falling edge and samples the outputs at the next falling edge, just before it drives again. Its reference model advances one slot per drive, so each comparison covers the effect of exactly one rising edge.

// File: rtl/ser7_pkg.sv
package ser7_pkg;

  // Default lane geometry.
  localparam int unsigned LANE_CNT = 4;
  localparam int unsigned SLOT_CNT = 7;
  localparam int unsigned WORD_W   = LANE_CNT * SLOT_CNT;

  // Frame-clock shape, slot 0 in the MSB.
  localparam logic [SLOT_CNT-1:0] FCLK_FRAME = 7'b1100011;

endpackage

// File: rtl/ser7_rise_det.sv
module ser7_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic wclk,
  output logic rise
);

  logic wclk_q;

  // Reset to 1 so that a word clock that is already high at reset release is not taken as an edge.
  always_ff @(posedge clk) begin
    if (rst) wclk_q <= 1'b1;
    else     wclk_q <= wclk;
  end

  assign rise = wclk & ~wclk_q & ~rst;

  // R1: two detected rises never arrive back to back.
  a_r1_single_rise: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/ser7_frame_ctrl.sv
module ser7_frame_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic pdown_n,
  input  logic rise,
  output logic load,
  output logic clr,
  output logic oe_q
);

  assign load = rise & pdown_n;
  assign clr  = ~pdown_n;

  always_ff @(posedge clk) begin
    if (rst)           oe_q <= 1'b0;
    else if (!pdown_n) oe_q <= 1'b0;
    else if (rise)     oe_q <= 1'b1;
  end

  // R5: power-down drops the enable at the next edge.
  a_r5_oe_drops: assert property (@(posedge clk) disable iff (rst)
    !pdown_n |=> !oe_q);

  // R6: the enable comes back only at a frame boundary.
  a_r6_oe_at_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> $past(rise));

  // R4: once running and powered, the enable stays high.
  a_r4_oe_persists: assert property (@(posedge clk) disable iff (rst)
    (oe_q && pdown_n) |=> oe_q);

endmodule

// File: rtl/ser7_lane_shifter.sv
module ser7_lane_shifter #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         sout
);

  logic [W-1:0] sreg;

  // Most significant bit leaves first; zeros fill in behind the frame.
  always_ff @(posedge clk) begin
    if (rst || clr) sreg <= '0;
    else if (load)  sreg <= load_val;
    else            sreg <= sreg << 1;
  end

  assign sout = sreg[W-1];

  // R2/R3: a load puts its first slot on the lane at the next edge.
  a_r2_load_first_slot: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> (sout == $past(load_val[W-1])));

  // R5: clearing silences the lane.
  a_r5_clear_silent: assert property (@(posedge clk) disable iff (rst)
    clr |=> (sout == 1'b0));

endmodule

// File: rtl/ser7_lane_tx.sv
module ser7_lane_tx #(
  parameter int unsigned P_LANES = ser7_pkg::LANE_CNT,
  parameter int unsigned P_SLOTS = ser7_pkg::SLOT_CNT,
  parameter logic [P_SLOTS-1:0] P_FCLK = ser7_pkg::FCLK_FRAME,
  localparam int unsigned P_WORD = P_LANES * P_SLOTS
) (
  input  logic               bit_clk,
  input  logic               rst,
  input  logic               word_clk,
  input  logic               pdown_n,
  input  logic [P_WORD-1:0]  tx_word,
  output logic [P_LANES-1:0] lane_dat,
  output logic               lane_fclk,
  output logic               lane_oe
);

  logic              rise;
  logic              load;
  logic              clr;
  logic [P_WORD-1:0] hold_q;

  ser7_rise_det u_rise (
    .clk  (bit_clk),
    .rst  (rst),
    .wclk (word_clk),
    .rise (rise)
  );

  ser7_frame_ctrl u_ctrl (
    .clk     (bit_clk),
    .rst     (rst),
    .pdown_n (pdown_n),
    .rise    (rise),
    .load    (load),
    .clr     (clr),
    .oe_q    (lane_oe)
  );

  // The word waits here for one word period, and keeps being captured while powered down.
  always_ff @(posedge bit_clk) begin
    if (rst)       hold_q <= '0;
    else if (rise) hold_q <= tx_word;
  end

  // R2: capture takes the word present at the detected rise.
  a_r2_word_capture: assert property (@(posedge bit_clk) disable iff (rst)
    rise |=> (hold_q == $past(tx_word)));

  for (genvar k = 0; k < P_LANES; k++) begin : g_lane
    ser7_lane_shifter #(.W(P_SLOTS)) u_sh (
      .clk      (bit_clk),
      .rst      (rst),
      .clr      (clr),
      .load     (load),
      .load_val (hold_q[k*P_SLOTS +: P_SLOTS]),
      .sout     (lane_dat[k])
    );
  end

  ser7_lane_shifter #(.W(P_SLOTS)) u_fclk (
    .clk      (bit_clk),
    .rst      (rst),
    .clr      (clr),
    .load     (load),
    .load_val (P_FCLK),
    .sout     (lane_fclk)
  );

endmodule

// File: tb/sim_ser7_lane_tx.sv
`timescale 1ns/1ps
module sim_ser7_lane_tx;

  typedef struct packed {
    logic [27:0] w;
    logic        pdn;
    logic        stall;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{28'h0000000, 1'b1, 1'b0},
    '{28'hFFFFFFF, 1'b1, 1'b0},
    '{28'hAAAAAAA, 1'b1, 1'b0},
    '{28'h5555555, 1'b1, 1'b0},
    '{28'h0000001, 1'b1, 1'b0},
    '{28'h8000000, 1'b1, 1'b0},
    '{28'h1234567, 1'b1, 1'b0},
    '{28'h0F0F0F0, 1'b1, 1'b1},
    '{28'h7654321, 1'b1, 1'b0},
    '{28'h3C3C3C3, 1'b0, 1'b0},
    '{28'h1111111, 1'b1, 1'b0},
    '{28'h6DB6DB6, 1'b1, 1'b0},
    '{28'h0000000, 1'b1, 1'b0}
  };
  localparam logic [6:0] PAT = 7'b1100011;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_clk = 1'b0;
  logic        pdown_n = 1'b1;
  logic [27:0] din = '0;
  logic [3:0]  lane_dat;
  logic        lane_fclk;
  logic        lane_oe;

  int checks = 0;
  int fails  = 0;
  int ph     = 6;
  bit done   = 1'b0;

  // Reference model state.
  logic [27:0] m_hold  = '0;
  logic [27:0] m_frame = '0;
  int          m_slot  = 7;
  logic        m_oe    = 1'b0;
  logic        m_wprev = 1'b1;
  logic        pd_cur  = 1'b1;

  always #2.5 clk = ~clk;

  ser7_lane_tx u0 (
    .bit_clk   (clk),
    .rst       (rst),
    .word_clk  (word_clk),
    .pdown_n   (pdown_n),
    .tx_word   (din),
    .lane_dat  (lane_dat),
    .lane_fclk (lane_fclk),
    .lane_oe   (lane_oe)
  );

  function automatic logic [5:0] expect_out();
    logic [3:0] d = '0;
    logic       f = 1'b0;
    if (m_oe && m_slot < 7) begin
      for (int k = 0; k < 4; k++) d[k] = m_frame[7*k + 6 - m_slot];
      f = PAT[6 - m_slot];
    end
    return {m_oe, f, d};
  endfunction

  // One bit-clock step: check what the last rising edge produced, then drive the next inputs.
  task automatic cyc(input logic [27:0] w, input bit adv, input bit pdn_v,
                     input bit rst_v, input string tag);
    logic [5:0] got;
    logic [5:0] exp;
    logic       rise_m;
    @(negedge clk);
    got = {lane_oe, lane_fclk, lane_dat};
    exp = expect_out();
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got oe/fclk/dat=%b expected %b", tag, got, exp);
    end
    if (adv) ph = (ph + 1) % 7;
    word_clk = (ph < 4);
    if (adv && ph == 0) din = w;
    pdown_n = pdn_v;
    rst = rst_v;
    if (rst_v) begin
      m_oe = 1'b0; m_hold = '0; m_slot = 7; m_wprev = 1'b1;
    end else begin
      rise_m  = word_clk && !m_wprev;
      m_wprev = word_clk;
      if (!pdn_v) begin
        m_oe = 1'b0; m_slot = 7;
      end else if (rise_m) begin
        m_frame = m_hold; m_slot = 0; m_oe = 1'b1;
      end else if (m_slot < 7) begin
        m_slot++;
      end
      if (rise_m) m_hold = din;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R7: reset state, with lanes low and enable low.
    for (int i = 0; i < 3; i++) cyc('0, 1'b0, 1'b1, 1'b1, "R7 reset");
    // R7: the first frame after reset carries zero data together with the clock pattern.
    for (int s = 0; s < 7; s++) cyc(28'h0ABCDEF, 1'b1, 1'b1, 1'b0, "R7 first frame");

    // Table walk: R2/R3/R4 normal, R8 stall, R5 power-down, R6 release.
    for (int i = 0; i < NVEC; i++) begin
      for (int s = 0; s < 7; s++) begin
        string tg;
        if (VEC[i].stall)                 tg = "R8 stall";
        else if (!VEC[i].pdn)             tg = "R5 power-down";
        else if (i > 0 && !VEC[i-1].pdn)  tg = "R6 resume";
        else                              tg = "R2 R3 R4 stream";
        if (s >= 3) pd_cur = VEC[i].pdn;
        cyc(VEC[i].w, !VEC[i].stall, pd_cur, 1'b0, tg);
      end
    end

    // R1: reset released while the word clock is high starts no frame.
    cyc(28'h2468ACE, 1'b1, 1'b1, 1'b0, "R1 setup");
    cyc(28'h2468ACE, 1'b1, 1'b1, 1'b0, "R1 setup");
    for (int i = 0; i < 3; i++) cyc('0, 1'b0, 1'b1, 1'b1, "R7 reset mid-run");
    for (int i = 0; i < 2; i++) cyc('0, 1'b0, 1'b1, 1'b0, "R1 high at release");
    for (int i = 0; i < 5; i++) cyc('0, 1'b1, 1'b1, 1'b0, "R1 no false rise");
    for (int s = 0; s < 7; s++) cyc(28'h9E3779B, 1'b1, 1'b1, 1'b0, "R1 R7 restart");
    for (int s = 0; s < 7; s++) cyc(28'h0000000, 1'b1, 1'b1, 1'b0, "R2 after restart");
    for (int s = 0; s < 7; s++) cyc(28'h0000000, 1'b1, 1'b1, 1'b0, "R2 flush");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule